// File: doc/BRIEF.md
# Protection Fault Response Controller

This block supervises an electronic power switch. It receives already-qualified analog event flags (supply out of range, thermal, current, short circuit, start-up timeout, switch health) together with a phase input that tells start-up from steady state. For each event it decides one of three outcomes: keep running, turn the switch off for as long as the condition lasts, or latch a fault. It drives the switch-enable output, a current-limit request, an active-low fault flag and a one-hot record of the latched cause.

Latched faults pass through a per-source qualification counter first. Once a fault is latched, the block either stays off until it is cleared (latch-off) or waits a programmable number of cycles and then restarts (auto-retry). The flag can be masked per cause, except for the start-up timeout. A fast-recovery option turns a short-circuit trip into a one-cycle turn-off followed by a current-limited restart, with no latch and no flag. Only a power-good reset or the enable input dropping below its deep shutdown level clears a latch.

Top module: `fault_resp_ctrl`

## Requirements
- R1: With `ev_uv`, `ev_ov` high or `en_uv_ok` low, `sw_en` is 0 in the same cycle and `flt_n` stays 1; nothing is latched and `sw_en` returns to 1 as soon as the condition goes away.
- R2: Latching sources set one bit of `cause`: bit0 overtemperature, bit1 overcurrent in steady state (`phase_steady`=1), bit2 short circuit with `cfg_sc_fast`=0, bit3 start-up timeout, bit4 gate-source health, bit5 gate-drain health; while `cause` is nonzero, `sw_en` is 0 and `flt_n` is 0 unless masked.
- R3: Overcurrent with `phase_steady`=0 raises `cur_lim` in the same cycle, never latches and leaves `flt_n` at 1.
- R4: A latching source is registered only if it stays high across `cfg_qdly`+1 consecutive rising clock edges; a shorter pulse leaves `cause` at 0.
- R5: `cfg_mask` bit i (i = 0..5) keeps `flt_n` at 1 for latched cause i; bit3 is ignored, so a start-up timeout always pulls `flt_n` low.
- R6: Sources that qualify in the same cycle latch only the lowest bit index; while latched, `cause` does not change when other sources qualify.
- R7: With `cfg_retry`=0, a latched fault keeps `cause` and `sw_en`=0 indefinitely until a clear condition.
- R8: With `cfg_retry`=1, `cause` and the flag stay set for `cfg_retry_cyc`+1 cycles after the latch, then clear and `sw_en` returns; a source still high needs the full qualification time again before it relatches.
- R9: `rst_n` low or `en_deep_ok` low clears `cause`, the flag and the retry timer (cleared on the next edge for `en_deep_ok`); `en_uv_ok` low alone leaves a latch in place.
- R10: With `cfg_sc_fast`=1, a qualified short circuit drives `sw_en` to 0 for exactly one cycle, then `cur_lim` stays 1 until `ev_sc` falls; no latch, `flt_n` stays 1, and no further off pulse while `ev_sc` stays high.
- R11: `ev_fet_ds` forces `sw_en` to 0 and `flt_n` to 0 while high, without latching; `cfg_mask` bit6 keeps `flt_n` at 1 for it.
- R12: After reset, with enable inputs high and no events, `sw_en`=1, `flt_n`=1, `cur_lim`=0 and `cause`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-good reset, clears everything |
| en_deep_ok | input | 1 | Enable above deep shutdown level; low clears the latch |
| en_uv_ok | input | 1 | Enable above undervoltage level; low turns the switch off |
| phase_steady | input | 1 | 1 = steady state, 0 = start-up |
| ev_uv | input | 1 | Supply undervoltage |
| ev_ov | input | 1 | Supply overvoltage |
| ev_ot | input | 1 | Overtemperature |
| ev_oc | input | 1 | Persistent overcurrent |
| ev_sc | input | 1 | Output short circuit |
| ev_sut | input | 1 | Start-up timeout |
| ev_fet_gs | input | 1 | Gate-source health fault |
| ev_fet_gd | input | 1 | Gate-drain health fault |
| ev_fet_ds | input | 1 | Drain-source health fault |
| cfg_retry | input | 1 | 1 = auto-retry, 0 = latch-off |
| cfg_sc_fast | input | 1 | Short-circuit fast recovery enable |
| cfg_mask | input | 7 | Flag mask per cause (bits 0..5) and drain-source fault (bit6) |
| cfg_qdly | input | QW | Qualification delay in cycles |
| cfg_retry_cyc | input | RW | Retry wait in cycles |
| sw_en | output | 1 | Switch enable |
| cur_lim | output | 1 | Current-limit request |
| flt_n | output | 1 | Active-low fault flag |
| cause | output | 6 | One-hot latched fault cause |

## Verification
A wrong qualification count shows at the ports as `cause` and `sw_en` changing one edge early or late relative to the held event, so the bench samples the edge before and the edge of the expected latch. A retry timer that is off by one or not reset shows as the flag releasing a cycle early or late after the latch, or after an enable clear. A stuck latch or a wrong priority choice appears in `cause` at once and stays visible until a clear, and a flaw in the fast-recovery state shows within two cycles as a missing or repeated off pulse on `sw_en`.

// File: rtl/fault_resp_ctrl.sv
module fault_resp_ctrl #(
  parameter int QW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_deep_ok,
  input  logic          en_uv_ok,
  input  logic          phase_steady,
  input  logic          ev_uv,
  input  logic          ev_ov,
  input  logic          ev_ot,
  input  logic          ev_oc,
  input  logic          ev_sc,
  input  logic          ev_sut,
  input  logic          ev_fet_gs,
  input  logic          ev_fet_gd,
  input  logic          ev_fet_ds,
  input  logic          cfg_retry,
  input  logic          cfg_sc_fast,
  input  logic [6:0]    cfg_mask,
  input  logic [QW-1:0] cfg_qdly,
  input  logic [RW-1:0] cfg_retry_cyc,
  output logic          sw_en,
  output logic          cur_lim,
  output logic          flt_n,
  output logic [5:0]    cause
);
  localparam int NF = 6;
  localparam int SC_BIT = 2;
  localparam int SUT_BIT = 3;

  logic [NF-1:0] src, qual, lq, pick, eff_mask;
  logic [QW-1:0] cnt [NF];
  logic [RW-1:0] rtmr;
  logic latched, flag_pull, fr_off, fr_lim, fr_go;

  assign latched  = |cause;
  assign src      = {ev_fet_gd, ev_fet_gs, ev_sut, ev_sc, ev_oc & phase_steady, ev_ot};
  assign lq       = qual & ~(NF'(cfg_sc_fast) << SC_BIT);
  assign pick     = lq & (~lq + NF'(1));
  assign eff_mask = cfg_mask[NF-1:0] & ~(NF'(1) << SUT_BIT);
  assign fr_go    = qual[SC_BIT] & cfg_sc_fast & ~fr_lim;

  for (genvar i = 0; i < NF; i++) begin : g_qual
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[i] <= '0;
      else if (!src[i] || latched || !en_deep_ok) cnt[i] <= '0;
      else if (cnt[i] != cfg_qdly) cnt[i] <= cnt[i] + QW'(1);
    end
    assign qual[i] = src[i] && (cnt[i] == cfg_qdly) && !latched;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0; flag_pull <= 1'b0; rtmr <= '0; fr_off <= 1'b0; fr_lim <= 1'b0;
    end else if (!en_deep_ok) begin
      cause <= '0; flag_pull <= 1'b0; rtmr <= '0; fr_off <= 1'b0; fr_lim <= 1'b0;
    end else begin
      fr_off <= fr_go;
      fr_lim <= fr_go | (fr_lim & ev_sc);
      if (!latched) begin
        cause     <= pick;
        flag_pull <= |(pick & ~eff_mask);
        rtmr      <= '0;
      end else if (cfg_retry) begin
        if (rtmr == cfg_retry_cyc) begin
          cause <= '0; flag_pull <= 1'b0; rtmr <= '0;
        end else begin
          rtmr <= rtmr + RW'(1);
        end
      end
    end
  end

  assign sw_en   = en_deep_ok & en_uv_ok & ~ev_uv & ~ev_ov & ~ev_fet_ds & ~latched & ~fr_off;
  assign cur_lim = (ev_oc & ~phase_steady) | fr_lim;
  assign flt_n   = ~(flag_pull | (ev_fet_ds & ~cfg_mask[6]));

  AST_SW_OFF_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != '0) |-> !sw_en);                                                  // R2
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause));                                                           // R6
  AST_SUT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cause[SUT_BIT] |-> !flt_n);                                                 // R5
  AST_LATCHOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause != '0) && !cfg_retry && en_deep_ok) |=> $stable(cause));            // R7
  AST_DEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_deep_ok |=> (cause == '0));                                             // R9
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_n |-> ((cause != '0) || ev_fet_ds));                                   // R11
endmodule

// File: tb/tb_fault_resp_ctrl.sv
module tb_fault_resp_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, en_deep_ok, en_uv_ok, phase_steady, ev_uv, ev_ov, ev_ot, ev_oc, ev_sc;
  logic ev_sut, ev_fet_gs, ev_fet_gd, ev_fet_ds, cfg_retry, cfg_sc_fast;
  logic [6:0] cfg_mask;
  logic [7:0] cfg_qdly;
  logic [15:0] cfg_retry_cyc;
  logic sw_en, cur_lim, flt_n;
  logic [5:0] cause;
  int total = 0, fails = 0;

  fault_resp_ctrl dut (.*);

  // {steady, en_uv_ok, uv, ov, oc, fet_ds, mask6} -> {sw_en, cur_lim, flt_n}
  localparam logic [9:0] VEC [9] = '{
    10'b1100000_101, 10'b1110000_001, 10'b1101000_001,
    10'b1000000_001, 10'b0100100_111, 10'b1100100_101,
    10'b1100010_000, 10'b1100011_001, 10'b0100000_101};

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clr();
    en_deep_ok = 1'b0; step(1);
    en_deep_ok = 1'b1; step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 0; en_deep_ok = 1; en_uv_ok = 1; phase_steady = 1;
    ev_uv = 0; ev_ov = 0; ev_ot = 0; ev_oc = 0; ev_sc = 0; ev_sut = 0;
    ev_fet_gs = 0; ev_fet_gd = 0; ev_fet_ds = 0;
    cfg_retry = 0; cfg_sc_fast = 0; cfg_mask = '0; cfg_qdly = 8'd3; cfg_retry_cyc = 16'd5;
    step(3); rst_n = 1; step(1);
    chk("R12", "sw_en", 32'(sw_en), 1); chk("R12", "flt_n", 32'(flt_n), 1);
    chk("R12", "cur_lim", 32'(cur_lim), 0); chk("R12", "cause", 32'(cause), 0);

    for (int i = 0; i < 9; i++) begin
      string tg;
      tg = (i == 4) ? "R3" : (i == 6 || i == 7) ? "R11" : "R1";
      {phase_steady, en_uv_ok, ev_uv, ev_ov, ev_oc, ev_fet_ds, cfg_mask[6]} = VEC[i][9:3];
      #1;
      chk(tg, $sformatf("vector %0d outputs", i), 32'({sw_en, cur_lim, flt_n}), 32'(VEC[i][2:0]));
      phase_steady = 1; en_uv_ok = 1; ev_uv = 0; ev_ov = 0; ev_oc = 0; ev_fet_ds = 0; cfg_mask[6] = 0;
      step(1);
    end
    chk("R1", "cause after level events", 32'(cause), 0);

    ev_ot = 1; step(3); ev_ot = 0; step(2);
    chk("R4", "short pulse cause", 32'(cause), 0);
    ev_ot = 1; step(3);
    chk("R4", "cause edge before", 32'(cause), 0);
    step(1);
    chk("R4", "cause at qualify", 32'(cause), 1);
    chk("R2", "sw_en latched", 32'(sw_en), 0); chk("R2", "flt_n latched", 32'(flt_n), 0);
    ev_ot = 0; step(20);
    chk("R7", "latch-off cause", 32'(cause), 1); chk("R7", "latch-off sw_en", 32'(sw_en), 0);
    en_uv_ok = 0; step(2); en_uv_ok = 1; step(1);
    chk("R9", "uv keeps latch", 32'(cause), 1);
    en_deep_ok = 0; step(1);
    chk("R9", "deep clear cause", 32'(cause), 0); chk("R9", "deep clear flt_n", 32'(flt_n), 1);
    en_deep_ok = 1; step(1);
    chk("R9", "sw_en after clear", 32'(sw_en), 1);

    ev_oc = 1; step(4);
    chk("R2", "breaker cause", 32'(cause), 2); chk("R2", "breaker cur_lim", 32'(cur_lim), 0);
    ev_oc = 0; clr();
    phase_steady = 0; ev_oc = 1; step(10);
    chk("R3", "startup oc cause", 32'(cause), 0); chk("R3", "startup oc cur_lim", 32'(cur_lim), 1);
    chk("R3", "startup oc flt_n", 32'(flt_n), 1);
    ev_oc = 0; phase_steady = 1; step(1);

    ev_sc = 1; step(4);
    chk("R2", "sc latched cause", 32'(cause), 4); chk("R2", "sc flt_n", 32'(flt_n), 0);
    ev_sc = 0; clr();

    cfg_mask = 7'h7F; ev_sut = 1; step(4);
    chk("R5", "sut cause", 32'(cause), 8); chk("R5", "sut flag unmaskable", 32'(flt_n), 0);
    ev_sut = 0; clr();
    ev_ot = 1; step(4);
    chk("R5", "masked ot cause", 32'(cause), 1); chk("R5", "masked ot flt_n", 32'(flt_n), 1);
    chk("R5", "masked ot sw_en", 32'(sw_en), 0);
    ev_ot = 0; clr(); cfg_mask = '0;

    ev_ot = 1; ev_fet_gd = 1; step(4);
    chk("R6", "priority ot over gd", 32'(cause), 1);
    ev_ot = 0; step(3);
    chk("R6", "cause frozen", 32'(cause), 1);
    ev_fet_gd = 0; clr();
    ev_fet_gs = 1; ev_fet_gd = 1; step(4);
    chk("R6", "priority gs over gd", 32'(cause), 16);
    ev_fet_gs = 0; ev_fet_gd = 0; clr();

    cfg_sc_fast = 1; ev_sc = 1; step(3);
    chk("R10", "before trip sw_en", 32'(sw_en), 1); chk("R10", "before trip cur_lim", 32'(cur_lim), 0);
    step(1);
    chk("R10", "off pulse sw_en", 32'(sw_en), 0); chk("R10", "off pulse cur_lim", 32'(cur_lim), 1);
    chk("R10", "no flag", 32'(flt_n), 1); chk("R10", "no latch", 32'(cause), 0);
    step(1);
    chk("R10", "restart sw_en", 32'(sw_en), 1); chk("R10", "restart cur_lim", 32'(cur_lim), 1);
    step(5);
    chk("R10", "no repeat sw_en", 32'(sw_en), 1); chk("R10", "still no latch", 32'(cause), 0);
    ev_sc = 0; step(1);
    chk("R10", "cur_lim released", 32'(cur_lim), 0);
    cfg_sc_fast = 0;

    cfg_retry = 1; ev_ot = 1; step(4);
    chk("R8", "retry latch", 32'(cause), 1);
    ev_ot = 0; step(5);
    chk("R8", "held before expiry", 32'(cause), 1); chk("R8", "flag held", 32'(flt_n), 0);
    step(1);
    chk("R8", "released cause", 32'(cause), 0); chk("R8", "released flt_n", 32'(flt_n), 1);
    chk("R8", "released sw_en", 32'(sw_en), 1);
    ev_ot = 1; step(4);
    chk("R8", "persistent latch", 32'(cause), 1);
    step(6);
    chk("R8", "persistent release", 32'(cause), 0);
    step(3);
    chk("R8", "requalify wait", 32'(cause), 0);
    step(1);
    chk("R8", "relatched", 32'(cause), 1);
    ev_ot = 0; step(2);
    clr();
    chk("R9", "timer clear cause", 32'(cause), 0);
    ev_ot = 1; step(4); ev_ot = 0; step(5);
    chk("R9", "timer restarted", 32'(cause), 1);
    step(1);
    chk("R9", "timer full period", 32'(cause), 0);
    cfg_retry = 0;

    ev_fet_gs = 1; step(4);
    chk("R2", "gs cause", 32'(cause), 16);
    ev_fet_gs = 0;
    rst_n = 0; step(1); rst_n = 1; step(1);
    chk("R9", "power reset cause", 32'(cause), 0); chk("R9", "power reset flt_n", 32'(flt_n), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule